// File: doc/BRIEF.md
# Flash Status Register Write Guard

This block keeps the status byte of a serial flash device and decides, one request at a time, whether a modifying operation may proceed. A command decoder upstream presents single-cycle strobes for set-latch, clear-latch, status write (with a data byte), page program, sector erase and bulk erase, together with the target address. The guard answers each modifying request with a one-cycle grant or deny pulse. It also keeps the write-enable latch and reports the status byte that a status read shifts out.

Two registered bits decide which requests are refused. The first is a 3-bit guard level, which fences off an upper part of the array. The second is a lock bit. When the lock bit is set and the active-low protect pin is held low, the lock bit and the level cannot be changed. The lock bit and the level survive the ordinary reset and are cleared only by the power-on reset. The cycle engine that carries out a granted operation feeds its busy flag back in, and no new modifying request is granted while that flag is high.

Top module: `fsr_guard`

## Requirements
- R1: `status_o` is laid out as follows: bit 0 equals `busy_i` in the same cycle, bit 1 is the write-enable latch, bits 4:2 are the guard level, bits 6:5 read 0 and bit 7 is the lock bit.
- R2: A set-latch strobe makes `wlatch_o` 1 after the next rising edge, and a clear-latch strobe makes it 0.
- R3: A modifying request (status write, program, sector erase, bulk erase) arriving while the latch is 0 or `busy_i` is 1 is denied, and the latch keeps its value.
- R4: A granted status write loads data bit 7 into the lock bit and data bits 4:2 into the guard level, ignores the other data bits and clears the latch.
- R5: While the lock bit is 1 and `prot_pin_n` is 0, a status write is denied, the lock bit and level are unchanged and the latch stays 1.
- R6: Level 0 protects no address. Levels 1 to 6 protect the top 1/64, 1/32, 1/16, 1/8, 1/4 and 1/2 of the 2^ADDR_W byte array, and level 7 protects all of it.
- R7: A program whose address is protected is denied. An otherwise allowed program to an unprotected address is granted and clears the latch.
- R8: A sector erase is denied when any byte of its aligned 2^SECT_W-byte sector is protected, even if the given address itself is not.
- R9: A bulk erase is denied whenever the guard level is nonzero.
- R10: `rst_n` low clears the latch, grant and deny but keeps the lock bit and level. `por_n` low clears all of them. Both resets are synchronous.
- R11: Each modifying request produces exactly one grant or deny pulse, one cycle long, after the next rising edge. Other cycles pulse neither. If several strobes occur together, the order of precedence is status write, program, sector erase, bulk erase, set-latch, clear-latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; keeps the lock bit and level |
| por_n | input | 1 | Synchronous power-on reset, active low; clears everything |
| prot_pin_n | input | 1 | Protect pin, active low |
| busy_i | input | 1 | Busy flag from the cycle engine |
| cmd_setwe | input | 1 | Set-latch strobe |
| cmd_clrwe | input | 1 | Clear-latch strobe |
| cmd_srwr | input | 1 | Status write strobe |
| srwr_data | input | 8 | Data byte of the status write |
| cmd_prog | input | 1 | Page program request |
| cmd_sect | input | 1 | Sector erase request |
| cmd_bulk | input | 1 | Bulk erase request |
| req_addr | input | ADDR_W | Target byte address of program or sector erase |
| status_o | output | 8 | Status byte |
| wlatch_o | output | 1 | Write-enable latch |
| grant_o | output | 1 | Request granted (one-cycle pulse) |
| deny_o | output | 1 | Request denied (one-cycle pulse) |

## Verification
The busy bit of the status byte is combinational and is due in the same cycle that `busy_i` changes. Every other result is registered: the grant or deny pulse, the latch and the stored lock and level bits change at the first rising edge after the strobe. The bench drives its inputs 1 ns after a falling edge and checks outputs at falling edges only. A result is therefore read at the falling edge that follows its capturing rising edge, and the busy bit is read 1 ns after it is driven. A behavioural model updated on each rising edge is compared with every output at every falling edge. Directed checks add fixed expected values at the level boundaries and for the sector-straddle case.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    // Number of fractional guard levels between "nothing" and "everything".
    localparam int LVL_N = 6;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SETWE,
        OP_CLRWE,
        OP_SRWR,
        OP_PROG,
        OP_SECT,
        OP_BULK
    } op_e;

    // Non-volatile part of the status byte.
    typedef struct packed {
        logic       lock;
        logic [2:0] lvl;
    } nv_t;

    // Volatile control state.
    typedef struct packed {
        logic wlatch;
        logic grant;
        logic deny;
    } ctl_t;

endpackage

// File: rtl/fsr_cmd_sel.sv
module fsr_cmd_sel
    import fsr_pkg::*;
(
    input  logic cmd_setwe,
    input  logic cmd_clrwe,
    input  logic cmd_srwr,
    input  logic cmd_prog,
    input  logic cmd_sect,
    input  logic cmd_bulk,
    output op_e  op
);

    // Fixed precedence: modifying requests first, then latch commands.
    always_comb begin
        op = OP_NONE;
        if (cmd_srwr)       op = OP_SRWR;
        else if (cmd_prog)  op = OP_PROG;
        else if (cmd_sect)  op = OP_SECT;
        else if (cmd_bulk)  op = OP_BULK;
        else if (cmd_setwe) op = OP_SETWE;
        else if (cmd_clrwe) op = OP_CLRWE;
    end

endmodule

// File: rtl/fsr_prot_map.sv
module fsr_prot_map #(
    parameter int TOPB = 6
) (
    input  logic [2:0]      lvl,
    input  logic [TOPB-1:0] top_bits,
    output logic            hit
);

    localparam int CODES = 8;

    logic [CODES-1:0] hit_vec;

    assign hit_vec[0]       = 1'b0;
    assign hit_vec[CODES-1] = 1'b1;

    // Level g fences the top 2^-(TOPB+1-g) of the array: the address is
    // inside when its upper TOPB+1-g bits are all ones.
    for (genvar g = 1; g <= TOPB; g++) begin : g_lvl
        localparam int K = TOPB + 1 - g;
        assign hit_vec[g] = &top_bits[TOPB-1 -: K];
    end

    assign hit = hit_vec[lvl];

endmodule

// File: rtl/fsr_nv_store.sv
module fsr_nv_store
    import fsr_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic wr_en,
    input  nv_t  wr_val,
    output nv_t  nv_q
);

    nv_t nv_d;

    always_comb begin
        nv_d = nv_q;
        if (wr_en) nv_d = wr_val;
    end

    always_ff @(posedge clk) begin
        if (!por_n) nv_q <= '0;
        else        nv_q <= nv_d;
    end

endmodule

// File: rtl/fsr_guard.sv
module fsr_guard
    import fsr_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int SECT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              prot_pin_n,
    input  logic              busy_i,
    input  logic              cmd_setwe,
    input  logic              cmd_clrwe,
    input  logic              cmd_srwr,
    input  logic [7:0]        srwr_data,
    input  logic              cmd_prog,
    input  logic              cmd_sect,
    input  logic              cmd_bulk,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [7:0]        status_o,
    output logic              wlatch_o,
    output logic              grant_o,
    output logic              deny_o
);

    localparam int TOPB = LVL_N;

    // Bits of the top TOPB address bits that lie inside one sector.
    function automatic logic [TOPB-1:0] sect_top_mask();
        logic [TOPB-1:0] m;
        for (int i = 0; i < TOPB; i++) begin
            m[i] = ((ADDR_W - TOPB + i) < SECT_W);
        end
        return m;
    endfunction

    localparam logic [TOPB-1:0] SECT_TOP_MASK = sect_top_mask();

    op_e             op;
    nv_t             nv_q;
    nv_t             nv_wval;
    logic            nv_we;
    ctl_t            ctl_d, ctl_q;
    logic [TOPB-1:0] top_bits;
    logic            hit;
    logic            hw_lock;
    logic            is_mod;
    logic            allow;
    logic            unused_ok;

    fsr_cmd_sel u_sel (
        .cmd_setwe (cmd_setwe),
        .cmd_clrwe (cmd_clrwe),
        .cmd_srwr  (cmd_srwr),
        .cmd_prog  (cmd_prog),
        .cmd_sect  (cmd_sect),
        .cmd_bulk  (cmd_bulk),
        .op        (op)
    );

    // Sector erase probes the highest byte of its sector: protection is an
    // upper range, so that byte is fenced whenever any byte is.
    assign top_bits = req_addr[ADDR_W-1 -: TOPB]
                    | ((op == OP_SECT) ? SECT_TOP_MASK : '0);

    fsr_prot_map #(.TOPB(TOPB)) u_map (
        .lvl      (nv_q.lvl),
        .top_bits (top_bits),
        .hit      (hit)
    );

    fsr_nv_store u_nv (
        .clk    (clk),
        .por_n  (por_n),
        .wr_en  (nv_we),
        .wr_val (nv_wval),
        .nv_q   (nv_q)
    );

    assign hw_lock   = nv_q.lock && !prot_pin_n;
    assign nv_wval   = '{lock: srwr_data[7], lvl: srwr_data[4:2]};
    assign unused_ok = ^{srwr_data[6:5], srwr_data[1:0], req_addr[ADDR_W-TOPB-1:0]};

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.grant = 1'b0;
        ctl_d.deny  = 1'b0;
        nv_we       = 1'b0;
        is_mod      = (op == OP_SRWR) || (op == OP_PROG)
                   || (op == OP_SECT) || (op == OP_BULK);
        allow       = ctl_q.wlatch && !busy_i;
        case (op)
            OP_SRWR:          allow = allow && !hw_lock;
            OP_PROG, OP_SECT: allow = allow && !hit;
            OP_BULK:          allow = allow && (nv_q.lvl == 3'd0);
            default:          ;
        endcase
        if (is_mod) begin
            if (allow) begin
                ctl_d.grant  = 1'b1;
                ctl_d.wlatch = 1'b0;
                nv_we        = (op == OP_SRWR);
            end else begin
                ctl_d.deny   = 1'b1;
            end
        end else if (op == OP_SETWE) begin
            ctl_d.wlatch = 1'b1;
        end else if (op == OP_CLRWE) begin
            ctl_d.wlatch = 1'b0;
        end
        if (!rst_n) begin
            ctl_d = '0;
            nv_we = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign status_o = {nv_q.lock, 2'b00, nv_q.lvl, ctl_q.wlatch, busy_i};
    assign wlatch_o = ctl_q.wlatch;
    assign grant_o  = ctl_q.grant;
    assign deny_o   = ctl_q.deny;

    // R2
    latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (op == OP_SETWE) |=> wlatch_o);

    // R3
    no_latch_deny_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (is_mod && (!wlatch_o || busy_i)) |=> (deny_o && $stable(wlatch_o)));

    // R5
    hw_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        ((op == OP_SRWR) && hw_lock) |=> ($stable(nv_q) && deny_o));

    // R9
    bulk_guard_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        ((op == OP_BULK) && (nv_q.lvl != 3'd0)) |=> deny_o);

    // R10
    warm_reset_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> ($stable(nv_q) && !wlatch_o && !grant_o && !deny_o));

    // R11
    one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        is_mod |=> (grant_o != deny_o));

    // R11
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        !is_mod |=> (!grant_o && !deny_o));

endmodule

// File: tb/sim_fsr_guard.sv
`timescale 1ns/1ps
module sim_fsr_guard;

    localparam int AW = 19;
    localparam int SW = 16;
    localparam int SZ = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          por_n = 1'b0;
    logic          prot_pin_n = 1'b1;
    logic          busy_i = 1'b0;
    logic          cmd_setwe = 1'b0;
    logic          cmd_clrwe = 1'b0;
    logic          cmd_srwr = 1'b0;
    logic [7:0]    srwr_data = 8'h00;
    logic          cmd_prog = 1'b0;
    logic          cmd_sect = 1'b0;
    logic          cmd_bulk = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    status_o;
    logic          wlatch_o, grant_o, deny_o;

    int n_chk = 0;
    int n_err = 0;
    bit started = 0;

    // behavioural reference state
    bit       m_wl, m_gr, m_dn, m_lock;
    bit [2:0] m_lvl;

    always #4 clk = ~clk;

    fsr_guard #(.ADDR_W(AW), .SECT_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .prot_pin_n(prot_pin_n),
        .busy_i(busy_i), .cmd_setwe(cmd_setwe), .cmd_clrwe(cmd_clrwe),
        .cmd_srwr(cmd_srwr), .srwr_data(srwr_data), .cmd_prog(cmd_prog),
        .cmd_sect(cmd_sect), .cmd_bulk(cmd_bulk), .req_addr(req_addr),
        .status_o(status_o), .wlatch_o(wlatch_o), .grant_o(grant_o),
        .deny_o(deny_o)
    );

    function automatic bit fenced(int lvl, int a);
        if (lvl == 0) return 0;
        if (lvl == 7) return 1;
        return a >= (SZ - (SZ >> (7 - lvl)));
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model, one step per rising edge
    always @(posedge clk) begin
        bit ok;
        int a;
        started = 1;
        if (!por_n) begin
            m_wl = 0; m_gr = 0; m_dn = 0; m_lock = 0; m_lvl = 0;
        end else if (!rst_n) begin
            m_wl = 0; m_gr = 0; m_dn = 0;
        end else begin
            m_gr = 0; m_dn = 0;
            ok = m_wl && !busy_i;
            a  = int'(req_addr);
            if (cmd_srwr || cmd_prog || cmd_sect || cmd_bulk) begin
                if (cmd_srwr)      ok = ok && !(m_lock && !prot_pin_n);
                else if (cmd_prog) ok = ok && !fenced(m_lvl, a);
                else if (cmd_sect) ok = ok && !fenced(m_lvl, (a / (1 << SW)) * (1 << SW) + (1 << SW) - 1);
                else               ok = ok && (m_lvl == 0);
                if (ok) begin
                    m_gr = 1; m_wl = 0;
                    if (cmd_srwr) begin
                        m_lock = srwr_data[7];
                        m_lvl  = srwr_data[4:2];
                    end
                end else begin
                    m_dn = 1;
                end
            end else if (cmd_setwe) m_wl = 1;
            else if (cmd_clrwe)     m_wl = 0;
        end
    end

    always @(negedge clk) begin
        if (started) begin
            chk("R1 status", int'(status_o), int'({m_lock, 2'b00, m_lvl, m_wl, busy_i}));
            chk("R2 latch", int'(wlatch_o), int'(m_wl));
            chk("R11 grant", int'(grant_o), int'(m_gr));
            chk("R11 deny", int'(deny_o), int'(m_dn));
        end
    end

    // drive one strobe, return at the falling edge where its result shows
    task automatic issue(input int kind, input logic [7:0] d, input int a);
        @(negedge clk); #1;
        srwr_data = d;
        req_addr  = AW'(a);
        case (kind)
            1: cmd_setwe = 1'b1;
            2: cmd_clrwe = 1'b1;
            3: cmd_srwr  = 1'b1;
            4: cmd_prog  = 1'b1;
            5: cmd_sect  = 1'b1;
            default: cmd_bulk = 1'b1;
        endcase
        @(posedge clk); #1;
        {cmd_setwe, cmd_clrwe, cmd_srwr, cmd_prog, cmd_sect, cmd_bulk} = '0;
        @(negedge clk);
    endtask

    task automatic set_lvl(input logic [7:0] d);
        issue(1, 8'h00, 0);
        issue(3, d, 0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset state", int'(status_o), 8'h00);

        // R1: busy bit follows input in the same cycle
        #1 busy_i = 1'b1;
        #1 chk("R1 busy bit", int'(status_o[0]), 1);
        @(negedge clk); #1 busy_i = 1'b0;

        // R2
        issue(1, 8'h00, 0);
        chk("R2 set", int'(wlatch_o), 1);
        issue(2, 8'h00, 0);
        chk("R2 clear", int'(wlatch_o), 0);

        // R3
        issue(4, 8'h00, 0);
        chk("R3 no latch deny", int'(deny_o), 1);
        issue(1, 8'h00, 0);
        @(negedge clk); #1 busy_i = 1'b1;
        issue(4, 8'h00, 0);
        chk("R3 busy deny", int'(deny_o), 1);
        chk("R3 latch kept", int'(wlatch_o), 1);
        @(negedge clk); #1 busy_i = 1'b0;

        // R4
        issue(3, 8'hFF, 0);
        chk("R4 grant", int'(grant_o), 1);
        chk("R4 status", int'(status_o), 8'h9C);

        // R5
        @(negedge clk); #1 prot_pin_n = 1'b0;
        set_lvl(8'h00);
        chk("R5 hw lock deny", int'(deny_o), 1);
        chk("R5 status kept", int'(status_o), 8'h9E);
        @(negedge clk); #1 prot_pin_n = 1'b1;
        issue(3, 8'h00, 0);
        chk("R5 pin high grant", int'(status_o), 8'h00);

        // R6, R7: each level at its boundary
        for (int c = 0; c < 8; c++) begin
            set_lvl(8'(c << 2));
            chk("R6 level stored", int'(status_o[4:2]), c);
            issue(1, 8'h00, 0);
            if (c == 0) begin
                issue(4, 8'h00, SZ - 1);
                chk("R6 level0 top grant", int'(grant_o), 1);
            end else if (c == 7) begin
                issue(4, 8'h00, 0);
                chk("R7 level7 deny", int'(deny_o), 1);
            end else begin
                issue(4, 8'h00, SZ - (SZ >> (7 - c)));
                chk("R7 boundary deny", int'(deny_o), 1);
                issue(4, 8'h00, SZ - (SZ >> (7 - c)) - 1);
                chk("R6 below boundary grant", int'(grant_o), 1);
                chk("R7 latch cleared", int'(wlatch_o), 0);
            end
        end

        // R8: level 1 fences only part of the top sector
        set_lvl(8'h04);
        issue(1, 8'h00, 0);
        issue(5, 8'h00, SZ - (1 << SW));
        chk("R8 straddle deny", int'(deny_o), 1);
        issue(5, 8'h00, SZ - (1 << SW) - 1);
        chk("R8 lower sector grant", int'(grant_o), 1);

        // R9
        issue(1, 8'h00, 0);
        issue(6, 8'h00, 0);
        chk("R9 bulk deny", int'(deny_o), 1);
        set_lvl(8'h00);
        issue(1, 8'h00, 0);
        issue(6, 8'h00, 0);
        chk("R9 bulk grant", int'(grant_o), 1);
        @(negedge clk);
        chk("R11 single pulse", int'(grant_o), 0);

        // R10
        set_lvl(8'h8C);
        issue(1, 8'h00, 0);
        @(negedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R10 warm reset keeps", int'(status_o), 8'h8C);
        #1 por_n = 1'b0;
        @(posedge clk); #1 por_n = 1'b1;
        @(negedge clk);
        chk("R10 power-on clears", int'(status_o), 8'h00);

        repeat (2) @(negedge clk);
        summary();
    end

endmodule